// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment-Derived Alternate Results

This block adds two 64-bit operands and a carry-in and returns a 64-bit sum and a carry-out. It has no clock or state. The operand bits are split into groups that get wider toward the most significant end, which follows square-root sizing.

The lowest group is a plain ripple-carry adder fed by the real carry-in. Each higher group works in three steps:

- It computes its slice once with a ripple-carry adder whose carry-in is tied to zero.
- It forms the carry-in-one answer by incrementing that zero-carry result, taken one bit wider with the carry included. A second adder is not used.
- The carry selected by the group below picks one of the two answers.

Each group's selected carry then becomes the select for the next group. Long carry ripples therefore stay inside one group, and the path from group to group is one multiplexer per group.

The block is meant as the fast adder inside a datapath. The width is a parameter. The group partition is computed from the width rather than listed by hand.

Top module: `sqcs_adder`

## Requirements
- R1: `{cout, sum}` equals the 65-bit value `a + b + cin` for every combination of inputs.
- R2: The outputs depend only on the present inputs. A change of inputs appears at the outputs without any clock edge, and there is no stored state.
- R3: The lowest group is 2 bits wide and adds `a[1:0]`, `b[1:0]` and the real `cin`. A carry generated or propagated in bits 1:0 reaches bit 2 of the sum.
- R4: Each higher group of width n forms its carry-in-one result by adding one to the (n+1)-bit value {zero-carry carry-out, zero-carry sum}. Output bit 0 is the inverse of input bit 0, and output bit i is input bit i XOR the AND of input bits 0 to i-1. An all-ones input wraps to all zeros.
- R5: A group outputs its zero-carry sum and carry when the incoming group carry is 0, and its incremented sum and carry when that carry is 1. Sum and carry are always chosen as a pair. A group whose bits all propagate passes the incoming carry straight through.
- R6: For a width of 64, the group widths from the least significant end are 2, 2, 3, 4, 5, 6, 7, 8, 9, 10 and 8. The group boundaries are therefore at bit positions 2, 4, 7, 11, 16, 22, 29, 37, 46 and 56, and a carry crossing each boundary produces the correct sum.
- R7: `cout` is the carry selected by the most significant group. It is 1 when the true sum reaches 2^64 or more.
- R8: With both operands zero and `cin` at 0, `sum` and `cout` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The bench sweeps the following input patterns, each of which isolates a different part of the structure:

- **Extreme operands** (zero, all-ones, alternating bits) catch errors in the final carry-out and in a whole-word carry ripple.
- **Carry at each group boundary.** For every boundary, one vector sends a carry in from below with the lower bits all ones, and one generates the carry at the top bit of the lower group. These show whether each multiplexer chooses the right result and whether the partition sits where it should.
- **Fully propagating operands** (b equal to the inverse of a, with either carry-in) make every group forward its incoming carry. This separates an incorrect increment from an incorrect selection.
- **Random operands** cover the remaining interaction between groups.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;

  // Nominal width of group g: two 2-bit groups, then 3, 4, 5 ...
  function automatic int seq_w(int g);
    return (g < 2) ? 2 : g + 1;
  endfunction

  // Number of groups for a total width w. Bits left over after the last
  // full nominal group form one narrower top group.
  function automatic int grp_count(int w);
    int used;
    int n;
    used = 0;
    n = 0;
    while (used + seq_w(n) <= w) begin
      used += seq_w(n);
      n++;
    end
    return (used < w) ? n + 1 : n;
  endfunction

  // Lowest bit index of group g.
  function automatic int grp_base(int w, int g);
    int used;
    used = 0;
    for (int i = 0; i < g; i++) used += seq_w(i);
    return (used < w) ? used : w;
  endfunction

  // Width of group g: nominal, or whatever remains for the top group.
  function automatic int grp_width(int w, int g);
    int base;
    base = grp_base(w, g);
    return (base + seq_w(g) <= w) ? seq_w(g) : w - base;
  endfunction

  // Single-bit full-adder sum.
  function automatic logic fa_sum(logic x, logic y, logic c);
    return x ^ y ^ c;
  endfunction

  // Single-bit full-adder carry.
  function automatic logic fa_carry(logic x, logic y, logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

endpackage

// File: rtl/sqcs_ripple.sv
module sqcs_ripple
  import sqcs_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  // Internal carry chain, brought out as named wires.
  logic [N:0] rc;

  assign rc[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum[i]  = fa_sum(a[i], b[i], rc[i]);
    assign rc[i+1] = fa_carry(a[i], b[i], rc[i]);
  end

  assign cout = rc[N];

  // R1: the bit-serial chain must agree with word arithmetic.
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      a_r1_ripple_exact: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
        else $error("ripple slice mismatch");
    end
  end

endmodule

// File: rtl/sqcs_excess1.sv
module sqcs_excess1 #(
  parameter int N = 5
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  // all_low[i] is the AND of din[0] .. din[i-1]; it is 1 for bit 0.
  logic [N-1:0] all_low;

  assign all_low[0] = 1'b1;

  for (genvar i = 1; i < N; i++) begin : g_and
    assign all_low[i] = all_low[i-1] & din[i-1];
  end

  // Bit 0 inverts; bit i toggles when every lower bit is 1.
  assign dout = din ^ all_low;

  // R4: gate-level toggling must equal an arithmetic increment.
  always_comb begin
    if (!$isunknown(din)) begin
      a_r4_plus_one: assert (dout == N'(din + 1'b1))
        else $error("converter is not an increment");
      // R4: an all-ones input wraps to zero.
      if (&din) begin
        a_r4_wrap_zero: assert (dout == '0)
          else $error("converter did not wrap");
      end
    end
  end

endmodule

// File: rtl/sqcs_group.sv
module sqcs_group #(
  parameter int N     = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sel,
  output logic [N-1:0] sum,
  output logic         cout
);

  if (FIRST) begin : g_low
    // Lowest group: the real carry-in goes straight into the adder.
    sqcs_ripple #(.N(N)) u_rca (
      .a    (a),
      .b    (b),
      .cin  (sel),
      .sum  (sum),
      .cout (cout)
    );
  end else begin : g_sel
    logic [N-1:0] sum_z;
    logic         cout_z;
    logic [N:0]   res_zero;
    logic [N:0]   res_one;

    sqcs_ripple #(.N(N)) u_rca (
      .a    (a),
      .b    (b),
      .cin  (1'b0),
      .sum  (sum_z),
      .cout (cout_z)
    );

    assign res_zero = {cout_z, sum_z};

    // One bit wider than the slice so that the carry is incremented too.
    sqcs_excess1 #(.N(N + 1)) u_inc (
      .din  (res_zero),
      .dout (res_one)
    );

    // Sum and carry are selected as one pair.
    assign {cout, sum} = sel ? res_one : res_zero;

    // R5: the selected pair equals the slice sum with the incoming carry.
    always_comb begin
      if (!$isunknown({a, b, sel})) begin
        a_r5_pair_select: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, sel}))
          else $error("group selection mismatch");
      end
    end
  end

endmodule

// File: rtl/sqcs_adder.sv
module sqcs_adder
  import sqcs_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NG = grp_count(WIDTH);

  // carry[g] selects in group g; carry[NG] is the final carry-out.
  logic [NG:0]    carry;
  logic [NG-1:0]  all_prop;

  assign carry[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int GW = grp_width(WIDTH, g);
    localparam int GB = grp_base(WIDTH, g);

    sqcs_group #(
      .N     (GW),
      .FIRST (g == 0)
    ) u_grp (
      .a    (a[GB +: GW]),
      .b    (b[GB +: GW]),
      .sel  (carry[g]),
      .sum  (sum[GB +: GW]),
      .cout (carry[g+1])
    );

    assign all_prop[g] = &(a[GB +: GW] ^ b[GB +: GW]);
  end

  assign cout = carry[NG];

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      // R1, R7: whole word against arithmetic.
      a_r1_total_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
        else $error("adder total mismatch");
      // R5: a fully propagating group forwards its incoming carry.
      for (int g = 0; g < NG; g++) begin
        if (all_prop[g]) begin
          a_r5_pass_through: assert (carry[g+1] == carry[g])
            else $error("propagating group altered carry");
        end
      end
    end
  end

endmodule

// File: tb/tb_sqcs_adder.sv
module tb_sqcs_adder;

  logic        clk;
  logic [63:0] a;
  logic [63:0] b;
  logic        cin;
  logic [63:0] sum;
  logic        cout;
  int          n_chk;
  int          n_fail;
  bit          done;

  sqcs_adder #(.WIDTH(64)) dut (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Directed table: operand a, operand b, carry-in, expected {cout,sum}.
  localparam int NT = 10;
  localparam logic [63:0] T_A [NT] = '{
    64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555,
    64'h8000_0000_0000_0000, 64'h3, 64'h0123_4567_89AB_CDEF};
  localparam logic [63:0] T_B [NT] = '{
    64'h0, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA,
    64'h8000_0000_0000_0000, 64'h1, 64'hFEDC_BA98_7654_3210};
  localparam logic T_C [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [64:0] T_E [NT] = '{
    65'h0,                       // R8 zero plus zero
    65'h1,                       // R3 carry-in enters lowest group
    65'h1_0000_0000_0000_0000,   // R7 all-ones plus one
    65'h1_FFFF_FFFF_FFFF_FFFF,   // R7 all-ones plus all-ones plus one
    65'h1_0000_0000_0000_0000,   // R5 carry-in crosses every group
    65'h0_FFFF_FFFF_FFFF_FFFF,   // R1 alternating bits
    65'h1_0000_0000_0000_0000,   // R5 alternating bits with carry-in
    65'h1_0000_0000_0000_0000,   // R7 top bits generate carry-out
    65'h0_0000_0000_0000_0004,   // R3 carry generated in bits 1:0
    65'h0_FFFF_FFFF_FFFF_FFFF};  // R1 mixed nibbles
  localparam int T_R [NT] = '{8, 3, 7, 7, 5, 1, 5, 7, 3, 1};

  // Boundaries implied by the 2,2,3,4,5,6,7,8,9,10,8 partition (R6).
  localparam int NB = 10;
  localparam int BND [NB] = '{2, 4, 7, 11, 16, 22, 29, 37, 46, 56};

  function automatic logic [64:0] ref_add(logic [63:0] x, logic [63:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {64'b0, c};
  endfunction

  task automatic check(string req, logic [64:0] exp);
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, {cout, sum}, exp);
    end
  endtask

  task automatic apply(logic [63:0] x, logic [63:0] y, logic c, string req);
    @(posedge clk);
    a = x;
    b = y;
    cin = c;
    @(negedge clk);
    check(req, ref_add(x, y, c));
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    a = '0;
    b = '0;
    cin = 1'b0;
    #1;
    check("R8 start-up with zero inputs", 65'h0);

    for (int i = 0; i < NT; i++) begin
      @(posedge clk);
      a = T_A[i];
      b = T_B[i];
      cin = T_C[i];
      @(negedge clk);
      check($sformatf("R%0d table entry %0d", T_R[i], i), T_E[i]);
    end

    // R2: outputs follow inputs with no clock edge in between.
    @(posedge clk);
    #2;
    a = 64'h0000_0000_0000_00FF;
    b = 64'h0000_0000_0000_0001;
    cin = 1'b0;
    #2;
    check("R2 first change mid-cycle", 65'h100);
    a = 64'hFFFF_FFFF_0000_0000;
    b = 64'h0000_0001_0000_0000;
    cin = 1'b1;
    #2;
    check("R2 second change mid-cycle", 65'h1_0000_0000_0000_0001);

    // R6: carries crossing each group boundary.
    for (int k = 0; k < NB; k++) begin
      apply((64'h1 << BND[k]) - 64'h1, 64'h0, 1'b1, "R6 carry-in ripples to boundary");
      apply(64'h1 << (BND[k] - 1), 64'h1 << (BND[k] - 1), 1'b0, "R6 carry generated below boundary");
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1 << (BND[k] - 1), 1'b0, "R6 carry into propagating upper groups");
      apply(64'h1 << BND[k], 64'h0, 1'b1, "R4 upper group without incoming carry");
    end

    // R5 and R4: every group propagates; the incoming carry decides all.
    for (int i = 0; i < 200; i++) begin
      logic [63:0] x;
      x = {$urandom, $urandom};
      apply(x, ~x, i[0], "R5 all groups propagate");
    end

    // R1: random operands.
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] x;
      logic [63:0] y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (i % 4 == 1) y = ~x ^ (64'h1 << (i % 64));
      apply(x, y, logic'($urandom & 1), "R1 random operands");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule